// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Register Bank

This block is the event-collection front of a multi-channel DMA engine. Each channel's data mover reports a finished transfer and four kinds of fault as single-cycle pulses. The bank latches those pulses into status words. Each status word holds one bit per channel. A processor reads the words over a flat 32-bit register port and clears individual bits by writing ones to them.

Two interrupt lines leave the block. The completion line is raised by any pending completion whose channel is not masked. The error line is raised by any latched fault on any channel, and it has no mask. The bank also holds the global enable, a self-clearing soft-reset command and the burst-timeout setting, which it drives out to the data movers.

Top module: `dma_irq_bank`

## Requirements
- R1: After `rst_ni` is asserted, every status word reads 0, the mask word reads all ones over the channel bits, and the control and burst-timeout words read 0. Both interrupt outputs are low.
- R2: Byte offsets are: control 0x00, completion status 0x04, completion mask 0x08, burst-timeout fault 0x0C, request-timeout fault 0x10, transfer fault 0x14, overflow fault 0x18, burst-timeout setting 0x1C. Reads return data combinationally, in the same cycle the address is presented.
- R3: A pulse on bit n of an event input sets bit n of the matching status word. The bit stays set until it is cleared.
- R4: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: If an event pulse and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R6: Mask bit n = 1 blocks channel n from the completion interrupt. `irq_done_o` is high exactly when some completion bit is set whose mask bit is 0.
- R7: `irq_err_o` is high exactly when any bit of the four fault words is set. Clearing one fault word leaves the line high while another fault bit remains set.
- R8: Control bit 0 is a read/write enable, driven on `ctrl_en_o`. Writing 1 to control bit 1 clears every status bit and sets every mask bit at that write's clock edge. This takes priority over coincident events. Bit 1 always reads 0.
- R9: In the burst-timeout setting word, bit 15 is the enable (`bto_en_o`) and bits 14:0 are the count (`bto_cnt_o`). Bits 31:16 read 0.
- R10: Status and mask bits at or above `NCH` read 0. Any offset not listed in R2 reads 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| done_evt_i | input | NCH | Per-channel completion pulses |
| bto_evt_i | input | NCH | Per-channel burst-timeout fault pulses |
| rto_evt_i | input | NCH | Per-channel request-timeout fault pulses |
| xfer_evt_i | input | NCH | Per-channel transfer fault pulses |
| ovf_evt_i | input | NCH | Per-channel overflow fault pulses |
| irq_done_o | output | 1 | Combined unmasked completion interrupt |
| irq_err_o | output | 1 | Combined fault interrupt |
| ctrl_en_o | output | 1 | Global enable |
| bto_en_o | output | 1 | Burst-timeout enable |
| bto_cnt_o | output | 15 | Burst-timeout count |

## Verification
A wrong status or mask bit inside the bank is visible at the ports in the very next cycle: reads are combinational and both interrupt lines are plain reductions of the latched words. A lost event, a clear that also hits a neighbour bit, or a soft reset that misses a word therefore shows up on the first readback of that word, or as a stuck or missing interrupt level. A wrong priority between set and clear shows up only when an event and a write meet on the same bit in the same cycle. The directed cases force exactly that collision.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int BTO_CNT_W = 15;
  localparam int ERR_KINDS = 4;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_MASK = 8'h08;
  localparam logic [7:0] OFF_ERR0 = 8'h0C;
  localparam logic [7:0] OFF_BTO  = 8'h1C;

  // fault words sit at consecutive words from OFF_ERR0
  function automatic logic [7:0] err_off(input int idx);
    return OFF_ERR0 + 8'(4 * idx);
  endfunction
endpackage

// File: rtl/w1c_word.sv
module w1c_word #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (clr_all_i) q_o <= '0;
    else                q_o <= (q_o & ~w1c_i) | set_i;  // set beats clear
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs import dma_irq_pkg::*; #(
  parameter int NCH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_ctrl_i,
  input  logic                 wr_mask_i,
  input  logic                 wr_bto_i,
  input  logic                 soft_rst_i,
  input  logic [31:0]          wdata_i,
  output logic                 en_o,
  output logic [NCH-1:0]       mask_o,
  output logic                 bto_en_o,
  output logic [BTO_CNT_W-1:0] bto_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      mask_o    <= '1;
      bto_en_o  <= 1'b0;
      bto_cnt_o <= '0;
    end else begin
      if (wr_ctrl_i) en_o <= wdata_i[0];
      if (soft_rst_i)     mask_o <= '1;
      else if (wr_mask_i) mask_o <= wdata_i[NCH-1:0];
      if (wr_bto_i) begin
        bto_en_o  <= wdata_i[15];
        bto_cnt_o <= wdata_i[BTO_CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank import dma_irq_pkg::*; #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NCH-1:0]       done_evt_i,
  input  logic [NCH-1:0]       bto_evt_i,
  input  logic [NCH-1:0]       rto_evt_i,
  input  logic [NCH-1:0]       xfer_evt_i,
  input  logic [NCH-1:0]       ovf_evt_i,
  output logic                 irq_done_o,
  output logic                 irq_err_o,
  output logic                 ctrl_en_o,
  output logic                 bto_en_o,
  output logic [BTO_CNT_W-1:0] bto_cnt_o
);
  logic [NCH-1:0] err_evt [ERR_KINDS];
  logic [NCH-1:0] err_q   [ERR_KINDS];
  logic [NCH-1:0] done_q, mask_q, err_or;
  logic           wr_ctrl, wr_stat, wr_mask, wr_bto, soft_rst;

  assign err_evt[0] = bto_evt_i;
  assign err_evt[1] = rto_evt_i;
  assign err_evt[2] = xfer_evt_i;
  assign err_evt[3] = ovf_evt_i;

  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_stat  = we_i && (addr_i == ADDR_W'(OFF_STAT));
  assign wr_mask  = we_i && (addr_i == ADDR_W'(OFF_MASK));
  assign wr_bto   = we_i && (addr_i == ADDR_W'(OFF_BTO));
  assign soft_rst = wr_ctrl && wdata_i[1];

  w1c_word #(.W(NCH)) u_done (
    .clk_i, .rst_ni,
    .clr_all_i (soft_rst),
    .set_i     (done_evt_i),
    .w1c_i     (wr_stat ? wdata_i[NCH-1:0] : '0),
    .q_o       (done_q)
  );

  for (genvar e = 0; e < ERR_KINDS; e++) begin : g_err
    logic wr_e;
    assign wr_e = we_i && (addr_i == ADDR_W'(err_off(e)));
    w1c_word #(.W(NCH)) u_err (
      .clk_i, .rst_ni,
      .clr_all_i (soft_rst),
      .set_i     (err_evt[e]),
      .w1c_i     (wr_e ? wdata_i[NCH-1:0] : '0),
      .q_o       (err_q[e])
    );
  end

  cfg_regs #(.NCH(NCH)) u_cfg (
    .clk_i, .rst_ni,
    .wr_ctrl_i  (wr_ctrl),
    .wr_mask_i  (wr_mask),
    .wr_bto_i   (wr_bto),
    .soft_rst_i (soft_rst),
    .wdata_i,
    .en_o       (ctrl_en_o),
    .mask_o     (mask_q),
    .bto_en_o,
    .bto_cnt_o
  );

  always_comb begin
    err_or = '0;
    for (int e = 0; e < ERR_KINDS; e++) err_or |= err_q[e];
  end

  assign irq_done_o = |(done_q & ~mask_q);
  assign irq_err_o  = |err_or;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL))      rdata_o = {31'b0, ctrl_en_o};
    else if (addr_i == ADDR_W'(OFF_STAT)) rdata_o = 32'(done_q);
    else if (addr_i == ADDR_W'(OFF_MASK)) rdata_o = 32'(mask_q);
    else if (addr_i == ADDR_W'(OFF_BTO))  rdata_o = {16'b0, bto_en_o, bto_cnt_o};
    else begin
      for (int e = 0; e < ERR_KINDS; e++)
        if (addr_i == ADDR_W'(err_off(e))) rdata_o = 32'(err_q[e]);
    end
  end
endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk import dma_irq_pkg::*; #(
  parameter int NCH    = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [NCH-1:0]    done_evt_i,
  input logic [NCH-1:0]    done_q,
  input logic [NCH-1:0]    mask_q,
  input logic              soft_rst,
  input logic              irq_done_o,
  input logic              irq_err_o
);
  assert_set_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst && (done_evt_i != '0)) |=> ((done_q & $past(done_evt_i)) == $past(done_evt_i)));

  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst && we_i && addr_i == ADDR_W'(OFF_STAT) && done_evt_i == '0)
      |=> (done_q == ($past(done_q) & ~$past(wdata_i[NCH-1:0]))));

  assert_soft_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (done_q == '0 && mask_q == '1));

  assert_done_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_done_o) |-> $past(we_i || (done_evt_i != '0)));

  assert_err_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_err_o) |-> $past(we_i));
endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .done_evt_i (done_evt_i),
  .done_q     (done_q),
  .mask_q     (mask_q),
  .soft_rst   (soft_rst),
  .irq_done_o (irq_done_o),
  .irq_err_o  (irq_err_o)
);

// File: tb/dma_irq_bank_tb.sv
`timescale 1ns/1ps
module dma_irq_bank_tb;
  localparam int NCH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NCH-1:0] done_evt_i = '0, bto_evt_i = '0, rto_evt_i = '0, xfer_evt_i = '0, ovf_evt_i = '0;
  logic        irq_done_o, irq_err_o, ctrl_en_o, bto_en_o;
  logic [14:0] bto_cnt_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model: index 0 completion, 1..4 fault words in offset order
  logic [NCH-1:0] m_stat [5];
  logic [NCH-1:0] m_mask;
  logic           m_en;
  logic [15:0]    m_bto;

  dma_irq_bank #(.NCH(NCH), .ADDR_W(8)) u_dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int widx(input logic [7:0] a);
    case (a)
      8'h04: return 0;
      8'h0C: return 1;
      8'h10: return 2;
      8'h14: return 3;
      8'h18: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_en};
    if (a == 8'h08) return 32'(m_mask);
    if (a == 8'h1C) return {16'b0, m_bto};
    if (widx(a) >= 0) return 32'(m_stat[widx(a)]);
    return '0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a == 8'h00) return "R2/R8";
    if (a == 8'h04) return "R2/R3";
    if (a == 8'h08) return "R2/R6";
    if (a == 8'h1C) return "R2/R9";
    if (widx(a) > 0) return "R2/R7";
    return "R10";
  endfunction

  function automatic logic exp_irq_err();
    return |(m_stat[1] | m_stat[2] | m_stat[3] | m_stat[4]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_stat[i] = '0;
    m_mask = '1; m_en = 0; m_bto = '0;
  endtask

  // drive in low phase, clock once, update model, return to low phase
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn, input logic [NCH-1:0] b, input logic [NCH-1:0] r,
                      input logic [NCH-1:0] x, input logic [NCH-1:0] o);
    logic [NCH-1:0] ev [5];
    we_i = we; addr_i = a; wdata_i = d;
    done_evt_i = dn; bto_evt_i = b; rto_evt_i = r; xfer_evt_i = x; ovf_evt_i = o;
    ev[0] = dn; ev[1] = b; ev[2] = r; ev[3] = x; ev[4] = o;
    @(posedge clk_i);
    if (we && a == 8'h00 && d[1]) begin
      for (int i = 0; i < 5; i++) m_stat[i] = '0;
      m_mask = '1;
    end else begin
      for (int i = 0; i < 5; i++)
        m_stat[i] = (m_stat[i] & ~((we && widx(a) == i) ? d[NCH-1:0] : '0)) | ev[i];
      if (we && a == 8'h08) m_mask = d[NCH-1:0];
    end
    if (we && a == 8'h00) m_en = d[0];
    if (we && a == 8'h1C) m_bto = d[15:0];
    @(negedge clk_i);
    we_i = 0; done_evt_i = '0; bto_evt_i = '0; rto_evt_i = '0; xfer_evt_i = '0; ovf_evt_i = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d, '0, '0, '0, '0, '0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    addr_i = a; we_i = 0;
    #1;
    chk(req, rdata_o, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] addrs [9];
    void'($urandom(32'd1234));
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20};
    model_reset();
    #20 rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    rd(8'h04, 0, "R1"); rd(8'h08, 32'h0000FFFF, "R1"); rd(8'h00, 0, "R1");
    rd(8'h1C, 0, "R1"); rd(8'h0C, 0, "R1");
    chk("R1", {irq_done_o, irq_err_o}, 0);

    // R3 completion latch, masked so no interrupt
    step(0, 8'h00, 0, 16'h0020, '0, '0, '0, '0);
    rd(8'h04, 32'h20, "R3");
    chk("R6", irq_done_o, 0);
    // R6 unmask channel 5, upper mask bits read zero (R10)
    wr(8'h08, 32'hFFFF_FFDF);
    rd(8'h08, 32'h0000FFDF, "R10");
    chk("R6", irq_done_o, 1);
    // R5 set beats clear
    step(1, 8'h04, 32'h20, 16'h0020, '0, '0, '0, '0);
    rd(8'h04, 32'h20, "R5");
    wr(8'h04, 32'h20);
    rd(8'h04, 0, "R4");
    chk("R6", irq_done_o, 0);
    // R4 selective clear
    step(0, 8'h00, 0, 16'h000A, '0, '0, '0, '0);
    wr(8'h04, 32'h2);
    rd(8'h04, 32'h8, "R4");
    // R7 fault OR across words
    step(0, 8'h00, 0, '0, 16'h0004, '0, 16'h0004, '0);
    chk("R7", irq_err_o, 1);
    wr(8'h0C, 32'h4);
    rd(8'h0C, 0, "R7");
    chk("R7", irq_err_o, 1);
    wr(8'h14, 32'h4);
    chk("R7", irq_err_o, 0);
    // R9 burst timeout setting
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0000FFFF, "R9");
    chk("R9", {bto_en_o, bto_cnt_o}, 16'hFFFF);
    wr(8'h1C, 32'h0000_1234);
    chk("R9", {bto_en_o, bto_cnt_o}, 16'h1234);
    // R8 enable and soft reset
    wr(8'h00, 32'h1);
    rd(8'h00, 1, "R8");
    chk("R8", ctrl_en_o, 1);
    wr(8'h08, 32'h0);
    step(0, 8'h00, 0, 16'hFFFF, '0, 16'h8001, '0, '0);
    step(1, 8'h00, 32'h3, 16'h0F0F, '0, '0, '0, 16'h0001);
    rd(8'h00, 1, "R8"); rd(8'h04, 0, "R8"); rd(8'h10, 0, "R8"); rd(8'h18, 0, "R8");
    rd(8'h08, 32'h0000FFFF, "R8");
    chk("R8", {irq_done_o, irq_err_o}, 0);
    // R10 unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R10"); rd(8'h05, 0, "R10"); rd(8'h08, 32'h0000FFFF, "R10");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ra, wa;
      logic [31:0] d;
      logic w;
      ra = addrs[$urandom_range(0, 8)];
      rd(ra, exp_read(ra), tag_of(ra));
      chk("R6", irq_done_o, |(m_stat[0] & ~m_mask));
      chk("R7", irq_err_o, exp_irq_err());
      w  = ($urandom_range(0, 9) < 4);
      wa = addrs[$urandom_range(0, 8)];
      d  = $urandom;
      if (wa == 8'h00 && $urandom_range(0, 7) != 0) d[1] = 1'b0;
      step(w, wa, d,
           NCH'($urandom & $urandom & $urandom), NCH'($urandom & $urandom & $urandom & $urandom),
           NCH'($urandom & $urandom & $urandom & $urandom), NCH'($urandom & $urandom & $urandom & $urandom),
           NCH'($urandom & $urandom & $urandom & $urandom));
    end
    finish_run();
  end
endmodule